// File: doc/BRIEF.md
# Radio Transceiver SPI Register Access Master

This block drives a four-wire SPI bus to a radio transceiver on behalf of on-chip logic. A command port takes an operation code, a 7-bit register address and a data byte. The block turns each accepted command into bus traffic and signals completion with a one-cycle `done` pulse. A read returns its result on `rdata`, and that value holds until the next read completes.

There are two kinds of transaction. A single-register write or read selects the device and sends an address byte whose top bit marks the direction. It then sends a second byte and deselects the device. A FIFO burst opens with one command byte and leaves chip select low. The burst then carries any number of data bytes, each issued as its own command, until a close command deselects the device. The bus runs in SPI mode 0 with 8-bit frames, MSB first. The SCLK half period is a parameter counted in system clock cycles.

Top module: `radio_spi_master`

## Requirements
- R1: `cmd_op` codes: 0 register write, 1 register read, 2 burst open, 3 burst byte, 4 burst close; codes 5 to 7 are ignored. A register write sends two bytes in one chip-select window: `{1, cmd_addr}` followed by `cmd_wdata`.
- R2: A register read sends `{0, cmd_addr}` followed by 0x00. The byte shifted in on MISO during the second byte appears on `rdata` when `done` pulses. `rdata` is 0 after reset and keeps its value through every other operation.
- R3: `cs_n` idles high and SCLK is low whenever `cs_n` is high. `cs_n` returns high after every register write and read.
- R4: Bits go out MSB first. MOSI changes only while SCLK is low, and MISO is sampled at each SCLK rising edge.
- R5: Each SCLK high and low phase inside a byte lasts exactly `HALF_CYCLES` system clocks. At least `HALF_CYCLES` clocks separate the `cs_n` fall from the first SCLK rise, and the same minimum separates the last SCLK fall from the `cs_n` rise. `cs_n` then stays high for at least `HALF_CYCLES` clocks before the next selection.
- R6: A burst open sends the single byte `{1, cmd_addr}` (0x80 for FIFO address 0). `done` then pulses with `cs_n` still low and `busy` low.
- R7: Each burst byte command sends exactly one byte, `cmd_wdata`, with `cs_n` held low, for any number of bytes.
- R8: A burst close sends no byte. It raises `cs_n` after the hold time and then pulses `done`.
- R9: A command is ignored while `busy` is high. Burst byte and burst close are ignored while no burst is open. Register write, register read and burst open are ignored while a burst is open.
- R10: `done` is a one-cycle pulse, and `busy` is low whenever `done` is high.
- R11: During reset `cs_n` is 1, SCLK is 0, `busy` is 0, `done` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_addr | input | DATA_W-1 | Register address |
| cmd_wdata | input | DATA_W | Write or burst data byte |
| busy | output | 1 | High while commands are not accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Result of the last register read |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with `HALF_CYCLES` = 3 and `DATA_W` = 8, which gives an SCLK near 8.3 MHz from a 50 MHz clock, inside the 10 MHz limit. With an odd half period, the divider counter must wrap in the middle of a byte and across the boundary between two bytes. It also makes the setup, hold and deselect windows several clocks long, so the bench can measure them against the bound instead of seeing a single-cycle coincidence. A device model answers reads with known bytes, and a monitor rebuilds each frame from the SCLK edges. This lets the bench check frame contents, burst continuity and the ignored commands at the pins.

// File: rtl/rspi_pkg.sv
package rspi_pkg;

  typedef enum logic [2:0] {
    OP_WRITE       = 3'd0,
    OP_READ        = 3'd1,
    OP_BURST_BEGIN = 3'd2,
    OP_BURST_BYTE  = 3'd3,
    OP_BURST_END   = 3'd4
  } rspi_op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SHIFT = 3'd1,
    S_HOLD  = 3'd2,
    S_DESEL = 3'd3,
    S_OPEN  = 3'd4
  } rspi_state_e;

  // direction flag placed in the top bit of the address byte
  localparam logic DIR_WRITE = 1'b1;
  localparam logic DIR_READ  = 1'b0;

endpackage

// File: rtl/rspi_half_timer.sv
// Produces one tick per SCLK half period while run is high.
// The count restarts whenever run is low, so the first tick comes
// exactly HALF_CYCLES clocks after run rises.
module rspi_half_timer #(
  parameter int unsigned HALF_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_CYCLES <= 1) begin : g_every_cycle
      assign tick = run;
    end else begin : g_counter
      localparam int unsigned CW = $clog2(HALF_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      assign tick = run && (cnt_q == LAST);

      always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/rspi_shifter.sv
// Mode 0 byte engine: drives SCLK and MOSI and samples MISO.
// A load presents the MSB at once. Each tick toggles SCLK: a rising
// edge samples MISO and a falling edge advances MOSI.
module rspi_shifter #(
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_byte,
  input  logic                  tick,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  byte_done,
  output logic [FRAME_BITS-1:0] rx_byte
);

  localparam int unsigned EDGES = 2 * FRAME_BITS;
  localparam int unsigned ECW   = $clog2(EDGES);
  localparam logic [ECW-1:0] LAST_EDGE = ECW'(EDGES - 1);

  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic [ECW-1:0]        edge_q, edge_d;
  logic                  sclk_q, sclk_d;
  logic                  act_q, act_d;
  logic                  last_edge;

  assign last_edge = (edge_q == LAST_EDGE);
  assign byte_done = act_q && tick && sclk_q && last_edge;
  assign sclk      = sclk_q;
  assign mosi      = tx_q[FRAME_BITS-1];
  assign rx_byte   = rx_q;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    edge_d = edge_q;
    sclk_d = sclk_q;
    act_d  = act_q;
    if (load) begin
      tx_d   = load_byte;
      edge_d = '0;
      sclk_d = 1'b0;
      act_d  = 1'b1;
    end else if (act_q && tick) begin
      edge_d = last_edge ? '0 : edge_q + 1'b1;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[FRAME_BITS-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (last_edge) act_d = 1'b0;
        else           tx_d  = {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      edge_q <= edge_d;
      sclk_q <= sclk_d;
      act_q  <= act_d;
    end
  end

endmodule

// File: rtl/rspi_seq.sv
// Transaction sequencer: accepts commands, orders the bytes,
// owns chip select and reports completion.
module rspi_seq
  import rspi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-2:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              tick,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              run,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  rspi_state_e       state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] second_q, second_d;
  logic              rd_q, rd_d;
  logic              burst_q, burst_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_q, done_d;

  assign run   = (state_q == S_SHIFT) || (state_q == S_HOLD) || (state_q == S_DESEL);
  assign busy  = !((state_q == S_IDLE) || (state_q == S_OPEN));
  assign cs_n  = cs_n_q;
  assign done  = done_q;
  assign rdata = rdata_q;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    second_d  = second_q;
    rd_d      = rd_q;
    burst_d   = burst_q;
    rdata_d   = rdata_q;
    done_d    = 1'b0;
    load      = 1'b0;
    load_byte = '0;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          case (cmd_op)
            OP_WRITE: begin
              load      = 1'b1;
              load_byte = {DIR_WRITE, cmd_addr};
              pend_d    = 1'b1;
              second_d  = cmd_wdata;
              rd_d      = 1'b0;
              burst_d   = 1'b0;
              state_d   = S_SHIFT;
            end
            OP_READ: begin
              load      = 1'b1;
              load_byte = {DIR_READ, cmd_addr};
              pend_d    = 1'b1;
              second_d  = '0;
              rd_d      = 1'b1;
              burst_d   = 1'b0;
              state_d   = S_SHIFT;
            end
            OP_BURST_BEGIN: begin
              load      = 1'b1;
              load_byte = {DIR_WRITE, cmd_addr};
              pend_d    = 1'b0;
              rd_d      = 1'b0;
              burst_d   = 1'b1;
              state_d   = S_SHIFT;
            end
            default: ;
          endcase
        end
      end
      S_SHIFT: begin
        if (byte_done) begin
          if (pend_q) begin
            load      = 1'b1;
            load_byte = second_q;
            pend_d    = 1'b0;
          end else begin
            if (rd_q) rdata_d = rx_byte;
            if (burst_q) begin
              state_d = S_OPEN;
              done_d  = 1'b1;
            end else begin
              state_d = S_HOLD;
            end
          end
        end
      end
      S_HOLD: begin
        if (tick) state_d = S_DESEL;
      end
      S_DESEL: begin
        if (tick) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_OPEN: begin
        if (cmd_valid) begin
          case (cmd_op)
            OP_BURST_BYTE: begin
              load      = 1'b1;
              load_byte = cmd_wdata;
              state_d   = S_SHIFT;
            end
            OP_BURST_END: begin
              burst_d = 1'b0;
              state_d = S_HOLD;
            end
            default: ;
          endcase
        end
      end
      default: state_d = S_IDLE;
    endcase
    cs_n_d = (state_d == S_IDLE) || (state_d == S_DESEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cs_n_q   <= 1'b1;
      pend_q   <= 1'b0;
      second_q <= '0;
      rd_q     <= 1'b0;
      burst_q  <= 1'b0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cs_n_q   <= cs_n_d;
      pend_q   <= pend_d;
      second_q <= second_d;
      rd_q     <= rd_d;
      burst_q  <= burst_d;
      rdata_q  <= rdata_d;
      done_q   <= done_d;
    end
  end

endmodule

// File: rtl/radio_spi_master.sv
module radio_spi_master #(
  parameter int unsigned HALF_CYCLES = 3,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-2:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;
  logic                   tick;
  logic                   run;
  logic                   load;
  logic [DATA_W-1:0]      load_byte;
  logic                   byte_done;
  logic [DATA_W-1:0]      rx_byte;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  rspi_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .tick  (tick)
  );

  rspi_shifter #(.FRAME_BITS(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load),
    .load_byte (load_byte),
    .tick      (tick),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  rspi_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .tick      (tick),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .load      (load),
    .load_byte (load_byte),
    .run       (run),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata)
  );

endmodule

// File: rtl/rspi_checker.sv
module rspi_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);

  // R3: the clock idles low whenever the device is deselected
  a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R4: MOSI holds through the whole high phase of SCLK
  a_r4_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R5: no clocking outside a chip-select window
  a_r5_clock_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  // R9: selection only follows a command offered while not busy
  a_r9_select_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(cmd_valid && !busy));

  // R10: completion is a single-cycle pulse
  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: the block is free whenever it reports completion
  a_r10_done_means_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind radio_spi_master rspi_checker u_rspi_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi)
);

// File: tb/radio_spi_master_tb_top.sv
module radio_spi_master_tb_top;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [6:0] cmd_addr = 7'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       busy, done, sclk, mosi, cs_n;
  logic [7:0] rdata;
  logic       miso = 1'b0;

  always #10 clk = ~clk;

  radio_spi_master #(.HALF_CYCLES(HALF), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- bus monitor and device model ----------------
  int         cyc = 0;
  logic       sclk_p = 1'b0, cs_p = 1'b1;
  logic [7:0] frame [16];
  int         nbytes = 0, nbit = 0;
  logic [7:0] sh_in = 8'd0;
  int         cs_fall_cyc = 0, cs_rise_cyc = 0, last_rise_cyc = 0, last_fall_cyc = 0;
  int         setup_cyc = 0, hold_cyc = 0, gap_cyc = 1000;
  int         half_viol = 0, cs_rises = 0, cs_falls = 0;
  logic       first_rise = 1'b0;
  logic [15:0] slv_sr = 16'd0;
  logic [7:0] slv_resp = 8'd0;

  always @(negedge clk) begin
    cyc++;
    if (cs_p && !cs_n) begin
      nbytes = 0; nbit = 0; cs_falls++;
      gap_cyc = cyc - cs_rise_cyc; cs_fall_cyc = cyc; first_rise = 1'b1;
      slv_sr = {8'h5A, slv_resp}; miso = slv_sr[15];
    end
    if (!cs_p && cs_n) begin
      cs_rise_cyc = cyc; hold_cyc = cyc - last_fall_cyc; cs_rises++;
    end
    if (!sclk_p && sclk) begin
      if (first_rise) begin setup_cyc = cyc - cs_fall_cyc; first_rise = 1'b0; end
      else if (nbit != 0 && (cyc - last_fall_cyc) != HALF) half_viol++;
      sh_in = {sh_in[6:0], mosi}; nbit++;
      if (nbit == 8) begin
        if (nbytes < 16) frame[nbytes] = sh_in;
        nbytes++; nbit = 0;
      end
      last_rise_cyc = cyc;
    end
    if (sclk_p && !sclk) begin
      if ((cyc - last_rise_cyc) != HALF) half_viol++;
      last_fall_cyc = cyc;
      slv_sr = {slv_sr[14:0], 1'b0}; miso = slv_sr[15];
    end
    sclk_p = sclk; cs_p = cs_n;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int lat = 0;
    while (!done && lat < 4000) begin @(negedge clk); lat++; end
    if (lat >= 4000) chk(1'b0, "R10", "done timeout", lat, 0);
    #1;
  endtask

  task automatic idle_wait(input int n, output int dcount);
    dcount = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    #1;
  endtask

  // op, addr, wdata, device reply, byte0, byte1, expected rdata
  localparam logic [49:0] VECS [6] = '{
    {3'd0, 7'h01, 8'h04, 8'h00, 8'h81, 8'h04, 8'h00},
    {3'd1, 7'h28, 8'h00, 8'h20, 8'h28, 8'h00, 8'h20},
    {3'd0, 7'h7F, 8'hA5, 8'h00, 8'hFF, 8'hA5, 8'h20},
    {3'd1, 7'h00, 8'h00, 8'hC3, 8'h00, 8'h00, 8'hC3},
    {3'd0, 7'h00, 8'h00, 8'h11, 8'h80, 8'h00, 8'hC3},
    {3'd1, 7'h7F, 8'h00, 8'hFF, 8'h7F, 8'h00, 8'hFF}
  };

  logic [2:0] v_op;
  logic [6:0] v_addr;
  logic [7:0] v_wd, v_resp, v_b0, v_b1, v_rd;
  logic [7:0] burst_data [5] = '{8'hFF, 8'h00, 8'h6C, 8'hC0, 8'hA5};
  int dcnt, falls0, rises0;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n == 1'b1, "R11", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0, "R11", "sclk in reset", sclk, 0);
    chk(busy == 1'b0, "R11", "busy in reset", busy, 0);
    chk(done == 1'b0, "R11", "done in reset", done, 0);
    chk(rdata == 8'h00, "R11", "rdata in reset", rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: register writes and reads (R1 R2 R3 R4 R5)
    for (int i = 0; i < 6; i++) begin
      {v_op, v_addr, v_wd, v_resp, v_b0, v_b1, v_rd} = VECS[i];
      slv_resp = v_resp;
      send(v_op, v_addr, v_wd);
      wait_done();
      chk(nbytes == 2, (v_op == 3'd0) ? "R1" : "R2", "byte count", nbytes, 2);
      chk(frame[0] == v_b0, (v_op == 3'd0) ? "R1" : "R2", "address byte", frame[0], v_b0);
      chk(frame[1] == v_b1, (v_op == 3'd0) ? "R1" : "R2", "second byte", frame[1], v_b1);
      chk(rdata == v_rd, "R2", "rdata", rdata, v_rd);
      chk(cs_n == 1'b1, "R3", "deselected after single access", cs_n, 1);
      chk(setup_cyc >= HALF, "R5", "cs setup", setup_cyc, HALF);
      chk(hold_cyc >= HALF, "R5", "cs hold", hold_cyc, HALF);
      chk(half_viol == 0, "R4", "half period", half_viol, 0);
      chk(busy == 1'b0, "R10", "free at done", busy, 0);
    end

    // R5: back-to-back accesses keep a deselect gap
    send(3'd0, 7'h13, 8'h0F);
    wait_done();
    chk(gap_cyc >= HALF, "R5", "deselect gap", gap_cyc, HALF);
    idle_wait(1, dcnt);
    chk(dcnt == 0 && done == 1'b0, "R10", "done one cycle", dcnt, 0);

    // R9: burst byte, burst close and undefined code while idle
    falls0 = cs_falls;
    send(3'd3, 7'h00, 8'h55);
    send(3'd4, 7'h00, 8'h00);
    send(3'd5, 7'h01, 8'h01);
    idle_wait(40, dcnt);
    chk(cs_falls == falls0, "R9", "idle ignores burst cmds", cs_falls, falls0);
    chk(dcnt == 0, "R9", "no done when ignored", dcnt, 0);

    // R6 R7 R8: FIFO burst
    slv_resp = 8'h00;
    rises0 = cs_rises;
    send(3'd2, 7'h00, 8'h00);
    wait_done();
    chk(nbytes == 1 && frame[0] == 8'h80, "R6", "burst command byte", frame[0], 8'h80);
    chk(cs_n == 1'b0, "R6", "cs held after open", cs_n, 0);
    chk(busy == 1'b0, "R6", "free while open", busy, 0);
    for (int j = 0; j < 5; j++) begin
      send(3'd3, 7'h00, burst_data[j]);
      wait_done();
      chk(frame[j+1] == burst_data[j], "R7", "burst data byte", frame[j+1], burst_data[j]);
      chk(cs_n == 1'b0, "R7", "cs low between bytes", cs_n, 0);
    end
    chk(nbytes == 6, "R7", "burst byte count", nbytes, 6);

    // R9: register access inside an open burst is ignored
    send(3'd0, 7'h05, 8'h05);
    send(3'd1, 7'h05, 8'h00);
    idle_wait(40, dcnt);
    chk(nbytes == 6 && cs_n == 1'b0, "R9", "open burst ignores register ops", nbytes, 6);
    chk(dcnt == 0, "R9", "no done in open burst", dcnt, 0);

    send(3'd4, 7'h00, 8'h00);
    wait_done();
    chk(cs_n == 1'b1, "R8", "cs released by close", cs_n, 1);
    chk(nbytes == 6, "R8", "close sends nothing", nbytes, 6);
    chk(hold_cyc >= HALF, "R8", "close hold", hold_cyc, HALF);
    chk(cs_rises == rises0 + 1, "R7", "single select window", cs_rises, rises0 + 1);
    chk(half_viol == 0, "R5", "half period in burst", half_viol, 0);

    // R9: a command offered while busy is dropped
    falls0 = cs_falls;
    slv_resp = 8'h3C;
    send(3'd0, 7'h11, 8'h22);
    send(3'd1, 7'h33, 8'h00);
    wait_done();
    idle_wait(80, dcnt);
    chk(cs_falls == falls0 + 1, "R9", "busy command dropped", cs_falls, falls0 + 1);
    chk(frame[0] == 8'h91 && frame[1] == 8'h22, "R1", "first write intact",
        {frame[0], frame[1]}, 16'h9122);
    chk(rdata == 8'hFF, "R2", "rdata held after write", rdata, 8'hFF);
    chk(dcnt == 0, "R9", "no extra done", dcnt, 0);

    finish_run();
  end

endmodule